// File: doc/BRIEF.md
# Container Filling Counter With Alarm

This block models the loading stage of a container filling line. While its mode input selects counting, an internal prescaler produces one loading event every `TICK_CYCLES` clock cycles (two seconds at a 100 MHz clock by default). Each event adds one item to the current container and to the running grand total. When the current container holds its programmed number of items, it is treated as full: the item count restarts at zero and the count of full containers goes up by one.

Loading halts on its own once the grand total equals the per-container limit times the container limit. The alarm output then goes high to enable an external sounder. While counting, the block also drives an eight-digit decimal display buffer with dot enables, so that a display multiplexer downstream can show all three counts. Leaving counting mode clears the block. The sounder's tone and the display scan are handled elsewhere. `TICK_CYCLES` can be set small to make simulation fast.

Top module: `fill_counter`

## Requirements
- R1: After reset, and whenever the mode input is 0, all counts are zero, the alarm is low, every display digit holds the blank code 10, and all eight dot enables are 1 (unlit).
- R2: While the mode input is 1 and the alarm is low, one item is loaded on every `TICK_CYCLES`-th clock edge, counted from the edge at which counting began. The first item appears after exactly `TICK_CYCLES` edges, and nothing changes between loading events.
- R3: Each loaded item increments the item count of the current container. When that count would reach the per-container limit, it returns to 0 and the full-container count increments.
- R4: Each loaded item increments the grand total. When the grand total reaches the per-container limit times the container limit, the alarm goes high on the same edge and all counts hold for as long as counting mode stays selected.
- R5: A mode input of 0 clears all three counts and the alarm at the next clock edge. Returning to mode 1 starts again from zero.
- R6: If either limit is 0, nothing is loaded and the alarm stays low.
- R7: A per-container limit above `ITEM_MAX` (50) acts as 50, and a container limit above `BOX_MAX` (18) acts as 18. Limits of 60 and 20 therefore finish after 900 items with 18 full containers.
- R8: In counting mode, digits_o holds eight 4-bit digits, with digit k at bits [4k+3:4k] and digit 0 rightmost. Digits 1:0 are the tens and ones of the current container's item count, digits 3:2 are the tens and ones of the full-container count, digits 6:4 are the hundreds, tens and ones of the grand total, and digit 7 is the blank code 10.
- R9: In counting mode, dots_n_o equals 8'b11101011 (bit k belongs to digit k, 0 = lit). This lights the dots of digits 2 and 4, which separate the three groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 100 MHz nominal |
| rst_n | input | 1 | Asynchronous reset, active low |
| count_mode_i | input | 1 | 1 selects counting, 0 holds the block cleared |
| item_limit_i | input | ITEM_IN_W | Items per container (values above ITEM_MAX act as ITEM_MAX) |
| box_limit_i | input | BOX_IN_W | Number of containers (values above BOX_MAX act as BOX_MAX) |
| digits_o | output | 32 | Eight decimal digits, 4 bits each, digit 0 in the low bits |
| dots_n_o | output | 8 | Active-low dot enables, one bit per digit |
| alarm_o | output | 1 | Sounder enable, high once the programmed total is loaded |

## Verification
All internal state is visible at the ports as decimal digits. A wrong prescaler phase therefore shows up as a digit that changes one or more edges early or late, and a wrong wrap or total comparison shows up as a container or total digit that differs at the first loading event where the fault applies. A missed stop shows up as the total digits still changing after the alarm rises. Because the bench compares every digit, the dots and the alarm on every cycle, a fault is reported in the cycle where it first appears at the outputs.

// File: rtl/fill_pkg.sv
package fill_pkg;

  localparam int unsigned NUM_DIGITS = 8;
  localparam logic [3:0]  BLANK_CODE = 4'd10;
  // active-low dots: lit on digit 2 and digit 4 (group separators)
  localparam logic [7:0]  SEP_DOTS_N = 8'b1110_1011;
  localparam logic [7:0]  ALL_DOTS_OFF = 8'hFF;

  // decimal digit of v at the given place value (1, 10, 100)
  function automatic logic [3:0] dec_digit(input int unsigned v, input int unsigned place);
    return 4'((v / place) % 10);
  endfunction

  // saturate a programmed limit at its maximum
  function automatic int unsigned sat_limit(input int unsigned v, input int unsigned mx);
    return (v > mx) ? mx : v;
  endfunction

endpackage

// File: rtl/fill_tick_gen.sv
module fill_tick_gen #(
  parameter int unsigned PERIOD = 200_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] phase_q;
  logic          at_last;

  assign at_last = (phase_q == LAST);
  assign tick_o  = en_i && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (!en_i || at_last) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  // R2: loading events never come on consecutive edges
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/fill_count_core.sv
module fill_count_core
  import fill_pkg::*;
#(
  parameter int unsigned ITEM_MAX  = 50,
  parameter int unsigned BOX_MAX   = 18,
  parameter int unsigned ITEM_IN_W = 6,
  parameter int unsigned BOX_IN_W  = 5,
  parameter int unsigned ITEM_W    = 6,
  parameter int unsigned BOX_W     = 5,
  parameter int unsigned TOT_W     = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run_i,
  input  logic [ITEM_IN_W-1:0] item_lim_i,
  input  logic [BOX_IN_W-1:0]  box_lim_i,
  input  logic                 tick_i,
  output logic                 active_o,
  output logic                 zero_lim_o,
  output logic [ITEM_W-1:0]    item_o,
  output logic [BOX_W-1:0]     box_o,
  output logic [TOT_W-1:0]     tot_o,
  output logic                 alarm_o
);
  logic [ITEM_W-1:0] item_lim, item_q;
  logic [BOX_W-1:0]  box_lim, box_q;
  logic [TOT_W-1:0]  tot_q;
  logic              alarm_q;
  int unsigned       target;
  logic              wrap_evt, finish_evt;

  assign item_lim   = ITEM_W'(sat_limit(32'(item_lim_i), ITEM_MAX));
  assign box_lim    = BOX_W'(sat_limit(32'(box_lim_i), BOX_MAX));
  assign target     = 32'(item_lim) * 32'(box_lim);
  assign zero_lim_o = (item_lim == '0) || (box_lim == '0);
  assign active_o   = run_i && !zero_lim_o && !alarm_q;

  assign wrap_evt   = tick_i && (32'(item_q) + 32'd1 >= 32'(item_lim));
  assign finish_evt = tick_i && (32'(tot_q) + 32'd1 >= target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      item_q <= '0; box_q <= '0; tot_q <= '0; alarm_q <= 1'b0;
    end else if (!run_i) begin
      item_q <= '0; box_q <= '0; tot_q <= '0; alarm_q <= 1'b0;
    end else if (tick_i) begin
      tot_q <= tot_q + 1'b1;
      if (wrap_evt) begin
        item_q <= '0;
        box_q  <= box_q + 1'b1;
      end else begin
        item_q <= item_q + 1'b1;
      end
      if (finish_evt) alarm_q <= 1'b1;
    end
  end

  assign item_o  = item_q;
  assign box_o   = box_q;
  assign tot_o   = tot_q;
  assign alarm_o = alarm_q;

  // R2: between loading events the total holds
  p_quiet_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_i) |=> $stable(tot_q));
  // R3: a full container restarts the item count and bumps the container count
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && wrap_evt) |=> (item_q == '0) && (box_q == $past(box_q) + 1'b1));
  // R4: once the alarm is up, loading is frozen
  p_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && alarm_q) |=> alarm_q && $stable(tot_q) && $stable(box_q));
  // R5: leaving counting mode clears everything
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (tot_q == '0) && (item_q == '0) && (box_q == '0) && !alarm_q);
  // R7: the total never exceeds the saturated product
  p_total_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tot_q) <= ITEM_MAX * BOX_MAX);

endmodule

// File: rtl/fill_display.sv
module fill_display
  import fill_pkg::*;
#(
  parameter int unsigned ITEM_W = 6,
  parameter int unsigned BOX_W  = 5,
  parameter int unsigned TOT_W  = 10
) (
  input  logic                    run_i,
  input  logic [ITEM_W-1:0]       item_i,
  input  logic [BOX_W-1:0]        box_i,
  input  logic [TOT_W-1:0]        tot_i,
  output logic [4*NUM_DIGITS-1:0] digits_o,
  output logic [NUM_DIGITS-1:0]   dots_n_o
);
  always_comb begin
    for (int k = 0; k < NUM_DIGITS; k++) digits_o[4*k +: 4] = BLANK_CODE;
    dots_n_o = ALL_DOTS_OFF;
    if (run_i) begin
      digits_o[3:0]   = dec_digit(32'(item_i), 1);
      digits_o[7:4]   = dec_digit(32'(item_i), 10);
      digits_o[11:8]  = dec_digit(32'(box_i), 1);
      digits_o[15:12] = dec_digit(32'(box_i), 10);
      digits_o[19:16] = dec_digit(32'(tot_i), 1);
      digits_o[23:20] = dec_digit(32'(tot_i), 10);
      digits_o[27:24] = dec_digit(32'(tot_i), 100);
      dots_n_o        = SEP_DOTS_N;
    end
  end

  // R8: every digit is a decimal value or the blank code
  always_comb begin
    for (int k = 0; k < NUM_DIGITS; k++)
      p_digit_range_r8: assert (digits_o[4*k +: 4] <= BLANK_CODE);
  end

endmodule

// File: rtl/fill_counter.sv
module fill_counter
  import fill_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 200_000_000,
  parameter int unsigned ITEM_MAX    = 50,
  parameter int unsigned BOX_MAX     = 18,
  parameter int unsigned ITEM_IN_W   = 6,
  parameter int unsigned BOX_IN_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 count_mode_i,
  input  logic [ITEM_IN_W-1:0] item_limit_i,
  input  logic [BOX_IN_W-1:0]  box_limit_i,
  output logic [31:0]          digits_o,
  output logic [7:0]           dots_n_o,
  output logic                 alarm_o
);
  localparam int unsigned ITEM_W = $clog2(ITEM_MAX + 1);
  localparam int unsigned BOX_W  = $clog2(BOX_MAX + 1);
  localparam int unsigned TOT_W  = $clog2(ITEM_MAX * BOX_MAX + 1);

  logic              active, tick, zero_lim;
  logic [ITEM_W-1:0] item_cnt;
  logic [BOX_W-1:0]  box_cnt;
  logic [TOT_W-1:0]  tot_cnt;

  fill_tick_gen #(.PERIOD(TICK_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(active), .tick_o(tick)
  );

  fill_count_core #(
    .ITEM_MAX(ITEM_MAX), .BOX_MAX(BOX_MAX),
    .ITEM_IN_W(ITEM_IN_W), .BOX_IN_W(BOX_IN_W),
    .ITEM_W(ITEM_W), .BOX_W(BOX_W), .TOT_W(TOT_W)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .run_i(count_mode_i),
    .item_lim_i(item_limit_i), .box_lim_i(box_limit_i),
    .tick_i(tick), .active_o(active), .zero_lim_o(zero_lim),
    .item_o(item_cnt), .box_o(box_cnt), .tot_o(tot_cnt), .alarm_o(alarm_o)
  );

  fill_display #(.ITEM_W(ITEM_W), .BOX_W(BOX_W), .TOT_W(TOT_W)) u_disp (
    .run_i(count_mode_i), .item_i(item_cnt), .box_i(box_cnt), .tot_i(tot_cnt),
    .digits_o(digits_o), .dots_n_o(dots_n_o)
  );

  // R6: a zero limit never yields a loading event or an alarm
  p_zero_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_mode_i && zero_lim) |-> !tick);
  p_zero_alarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_mode_i && $past(count_mode_i) && zero_lim && $past(zero_lim) && !$past(alarm_o)) |-> !alarm_o);

endmodule

// File: tb/fill_counter_tb.sv
module fill_counter_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       mode  = 1'b0;
  logic [5:0] il    = '0;
  logic [4:0] bl    = '0;
  wire [31:0] digits;
  wire [7:0]  dots;
  wire        alarm;

  fill_counter #(.TICK_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .count_mode_i(mode),
    .item_limit_i(il), .box_limit_i(bl),
    .digits_o(digits), .dots_n_o(dots), .alarm_o(alarm)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  // behavioural reference
  int m_phase = 0, m_item = 0, m_box = 0, m_tot = 0;
  bit m_alarm = 0;

  always @(posedge clk) begin
    int pl, bx;
    pl = (il > 50) ? 50 : int'(il);
    bx = (bl > 18) ? 18 : int'(bl);
    if (!rst_n || !mode) begin
      m_phase = 0; m_item = 0; m_box = 0; m_tot = 0; m_alarm = 0;
    end else if (pl == 0 || bx == 0 || m_alarm) begin
      m_phase = 0;
    end else if (m_phase == N - 1) begin
      m_phase = 0;
      m_tot++;
      m_item++;
      if (m_item >= pl) begin m_item = 0; m_box++; end
      if (m_tot >= pl * bx) m_alarm = 1;
    end else begin
      m_phase++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_digit(input int k);
    if (!mode) return 10;
    case (k)
      0: return m_item % 10;
      1: return (m_item / 10) % 10;
      2: return m_box % 10;
      3: return (m_box / 10) % 10;
      4: return m_tot % 10;
      5: return (m_tot / 10) % 10;
      6: return (m_tot / 100) % 10;
      default: return 10;
    endcase
  endfunction

  task automatic compare_all();
    for (int k = 0; k < 8; k++) begin
      string r;
      r = (k < 2) ? "R3 item digit" : (k < 4) ? "R3 box digit" :
          (k < 7) ? "R4 total digit" : "R8 blank digit";
      chk(r, int'(digits[4*k +: 4]), exp_digit(k));
    end
    chk("R9 dots", int'(dots), mode ? 8'hEB : 8'hFF);
    chk("R4 alarm", int'(alarm), int'(m_alarm));
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  initial begin
    step(2);
    chk("R1 reset digits", int'(digits == 32'hAAAA_AAAA), 1);
    chk("R1 reset dots", int'(dots), 8'hFF);
    chk("R1 reset alarm", int'(alarm), 0);
    rst_n = 1'b1;
    step(2);

    // R2 first event timing, R3/R4 small run
    il = 6'd3; bl = 5'd2; mode = 1'b1;
    step(N - 1);
    chk("R2 no item yet", int'(digits[3:0]), 0);
    step(1);
    chk("R2 first item", int'(digits[3:0]), 1);
    step(5 * N);
    chk("R4 alarm at total", int'(alarm), 1);
    chk("R3 boxes full", int'(digits[11:8]), 2);
    chk("R4 total six", int'(digits[19:16]), 6);
    step(12);
    chk("R4 total held", int'(digits[19:16]), 6);

    // R5 leave and re-enter
    mode = 1'b0; step(1);
    chk("R5 alarm cleared", int'(alarm), 0);
    chk("R1 blank when idle", int'(digits == 32'hAAAA_AAAA), 1);
    mode = 1'b1; step(1);
    chk("R5 restart at zero", int'(digits[27:0]), 0);

    // R6 zero limits
    il = 6'd0; bl = 5'd5; step(10 * N);
    chk("R6 zero item limit alarm", int'(alarm), 0);
    chk("R6 zero item limit total", int'(digits[19:16]), 0);
    il = 6'd4; bl = 5'd0; step(10 * N);
    chk("R6 zero box limit alarm", int'(alarm), 0);
    chk("R6 zero box limit total", int'(digits[19:16]), 0);

    // R3/R8 two-digit values, then R5 mid-run exit
    mode = 1'b0; step(1);
    il = 6'd12; bl = 5'd3; mode = 1'b1;
    step(15 * N);
    chk("R3 item after wrap", int'(digits[7:0]), 8'h03);
    chk("R3 box after wrap", int'(digits[15:8]), 8'h01);
    chk("R8 total tens", int'(digits[27:16]), 12'h015);
    step(8 * N);
    mode = 1'b0; step(1);
    chk("R5 mid-run clear", int'(alarm), 0);
    mode = 1'b1; step(1);
    chk("R5 mid-run restart", int'(digits[27:0]), 0);

    // R7 saturated limits: 50 x 18 = 900 items
    mode = 1'b0; step(1);
    il = 6'd60; bl = 5'd20; mode = 1'b1;
    step(900 * N - 1);
    chk("R7 not done before 900", int'(alarm), 0);
    step(1);
    chk("R7 done at 900", int'(alarm), 1);
    chk("R7 R8 final display", int'(digits), 32'hA900_1800);
    step(10);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule